// File: doc/BRIEF.md
# Self-Recovering Reduced-Width Ring Sequencer

This block steps through a fixed cyclic sequence of states. It is meant to drive control phases in logic that has to keep running after transient bit upsets. It holds N states in N-1 flip-flops. State 0 is encoded as the register holding no set bit. Every other state k is encoded as a single set bit at register position k-1. The per-state outputs are decoded directly from the register bits, so a consumer needs only one wire per phase.

The ring repairs itself without a reset. When the register is empty, a NOR of all the bits loads a 1 into the first stage. This single path produces the normal wrap from state 0 to state 1, and it also restarts the ring if an upset clears its only set bit. The last stage is not fed back. Any surplus 1s left by an upset therefore leave the register within N-1 enabled cycles. While more than one bit is set, the block raises a recovery flag.

A fault-injection mask input models upsets. For one cycle it XORs the register with the mask, which lets verification place the register in any pattern through the normal ports.

Top module: `mhot_ring_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no further clocking, the register is empty. state_o then equals 1 (bit 0 only) and recover_o is 0.
- R2: The register is N-1 bits wide. state_o[0] is high exactly when the register is empty. state_o[k] for k = 1..N-1 equals register bit k-1.
- R3: With en_i high and upset_i zero, a register holding at most one set bit advances by one state per clock. State N-1 is followed by state 0, and state 0 is followed by state 1.
- R4: With en_i low and upset_i zero, the register and all outputs hold their values.
- R5: A nonzero upset_i XORs the register with upset_i at the next clock and suppresses the shift in that cycle, whatever the value of en_i.
- R6: recover_o is high in every cycle in which the register holds two or more set bits, and low otherwise.
- R7: With en_i high and upset_i zero, the register moves each cycle to its contents shifted up by one position. The top bit is discarded, and a 1 enters bit 0 only when the register was empty. From any pattern, at most N-1 such cycles bring it back to at most one set bit.
- R8: An upset that clears the only set bit leaves the legal state 0 with recover_o low. Sequencing then continues from state 1.
- R9: A multi-bit pattern persists while en_i is low, and recover_o stays high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the ring by one state per cycle |
| upset_i | input | N-1 | Fault-injection mask, XORed into the register for one cycle |
| state_o | output | N | Per-state decoded outputs |
| recover_o | output | 1 | High while the register holds more than one set bit |

## Verification
The assertions on advance and hold apply only in cycles where upset_i is zero, because an injection overrides the shift. The advance check also requires the ring to be healthy, since multi-bit patterns do not follow the single-hot successor rule. The stimulus drives upset_i for single isolated cycles and keeps it zero in every other cycle. An exhaustive sweep therefore loads every possible register pattern and then observes pure shifting and holding. Each recovery run lasts N-1 enabled cycles with injection off, and the bench tracks the expected register value arithmetically.

// File: rtl/mhot_ring_pkg.sv
package mhot_ring_pkg;
  localparam int unsigned RING_DEF_STATES = 8;

  function automatic int unsigned ring_cnt_w(input int unsigned bits);
    return $clog2(bits + 1);
  endfunction
endpackage

// File: rtl/mhot_ring_reg.sv
module mhot_ring_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] upset_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         empty;

  assign empty = ~|q_q;

  always_comb begin
    q_d = q_q;
    if (|upset_i)  q_d = q_q ^ upset_i;
    else if (en_i) q_d = {q_q[W-2:0], empty};  // top stage drops out, no feedback
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && upset_i == '0) |=> $stable(q_q));

  assert_no_growth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && upset_i == '0 && q_q != '0) |=> ($countones(q_q) <= $countones($past(q_q))));

  assert_empty_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && upset_i == '0 && q_q == '0) |=> (q_q[0] && $countones(q_q) == 1));
endmodule

// File: rtl/mhot_ring_decode.sv
module mhot_ring_decode #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N - 1
) (
  input  logic [W-1:0] q_i,
  output logic [N-1:0] dec_o
);
  assign dec_o[0] = ~|q_i;

  for (genvar k = 1; k < N; k++) begin : g_dec
    assign dec_o[k] = q_i[k-1];
  end
endmodule

// File: rtl/mhot_ring_monitor.sv
module mhot_ring_monitor
  import mhot_ring_pkg::*;
#(
  parameter int unsigned W = 7,
  localparam int unsigned CW = ring_cnt_w(W)
) (
  input  logic [W-1:0] q_i,
  output logic         multi_o
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(W); i++) cnt = cnt + CW'(q_i[i]);
  end

  assign multi_o = (cnt > CW'(1));
endmodule

// File: rtl/mhot_ring_seq.sv
module mhot_ring_seq
  import mhot_ring_pkg::*;
#(
  parameter int unsigned NUM_STATES = RING_DEF_STATES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NUM_STATES-2:0] upset_i,
  output logic [NUM_STATES-1:0] state_o,
  output logic                  recover_o
);
  localparam int unsigned W = NUM_STATES - 1;

  logic [W-1:0] ring_q;

  mhot_ring_reg #(.W(W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .upset_i (upset_i),
    .q_o     (ring_q)
  );

  mhot_ring_decode #(.N(NUM_STATES)) u_dec (
    .q_i   (ring_q),
    .dec_o (state_o)
  );

  mhot_ring_monitor #(.W(W)) u_mon (
    .q_i     (ring_q),
    .multi_o (recover_o)
  );

  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && upset_i == '0 && !recover_o) |=>
      (state_o == {$past(state_o[NUM_STATES-2:0]), $past(state_o[NUM_STATES-1])}));

  assert_healthy_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recover_o |-> $onehot(state_o));

  assert_flag_multi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(state_o[NUM_STATES-1:1]) > 1) |-> recover_o);

  assert_flag_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(state_o[NUM_STATES-1:1]) <= 1) |-> !recover_o);

  always_comb begin
    if (!rst_ni) assert_reset_state_R1: assert (state_o == NUM_STATES'(1) && !recover_o);
  end
endmodule

// File: tb/sim_mhot_ring_seq.sv
`timescale 1ns/1ps
module sim_mhot_ring_seq;
  localparam int N = 8;
  localparam int W = N - 1;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] upset = '0;
  logic [N-1:0] state;
  logic         recover;

  int checks = 0;
  int errors = 0;
  int m = 0;  // expected register contents

  always #4 clk = ~clk;

  mhot_ring_seq #(.NUM_STATES(N)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .upset_i   (upset),
    .state_o   (state),
    .recover_o (recover)
  );

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < W; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int exp_dec(input int v);
    return ((v << 1) | (v == 0 ? 1 : 0)) & ((1 << N) - 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " state"}, int'(state), exp_dec(m));
    chk({tag, " recover"}, int'(recover), ones(m) > 1 ? 1 : 0);
  endtask

  // drive at negedge, clock, sample at next negedge
  task automatic cyc(input logic e, input int up);
    en = e;
    upset = W'(up);
    @(posedge clk);
    @(negedge clk);
    if (up != 0)  m = m ^ up;
    else if (e)   m = ((m << 1) | (m == 0 ? 1 : 0)) & FULL;
    en = 1'b0;
    upset = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    m = 0;
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2/R3: two full laps, state index = cycle mod N
    for (int c = 1; c <= 2 * N; c++) begin
      cyc(1'b1, 0);
      chk("R3 lap", int'(state), 1 << (c % N));
      chk("R2 decode", int'(state), exp_dec(m));
    end

    // R4: hold at state 3
    for (int c = 0; c < 3; c++) cyc(1'b1, 0);
    for (int c = 0; c < 5; c++) begin
      cyc(1'b0, 0);
      chk("R4 hold", int'(state), 1 << 3);
    end

    // R8: clear the only set bit (state 3 -> empty)
    cyc(1'b0, 1 << 2);
    chk("R8 cleared", int'(state), 1);
    chk("R8 no flag", int'(recover), 0);
    cyc(1'b1, 0);
    chk("R8 resume", int'(state), 2);

    // R5/R6/R7/R9: every register pattern, injected with en high
    for (int pat = 0; pat <= FULL; pat++) begin
      cyc(1'b1, m ^ pat);
      chk("R5 inject", int'(state), exp_dec(pat));
      compare("R6 after inject");
      if (ones(pat) > 1) begin
        for (int c = 0; c < 2; c++) begin
          cyc(1'b0, 0);
          compare("R9 held multi");
        end
      end
      for (int c = 0; c < W; c++) begin
        cyc(1'b1, 0);
        compare("R7 shift");
      end
      chk("R7 recovered", int'(recover), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule